// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter with a three-and-a-half digit readout. It repeats a three-phase cycle. First comes an autozero interval, in which the analog inputs are shorted to common and the offset-nulling loop is closed. Next is a signal integration of fixed length. Last is a reference de-integration, whose length is the measurement. Each phase has its own enable, and exactly one enable is high at any time.

At the end of integration the block samples the synchronized comparator to learn the sign of the input. It then applies the reference with the opposite polarity and counts clocks in BCD until the comparator changes state. The count at that point is the reading, 1000 × Vin / Vref. The reading and the sign are then copied into display registers, which hold their value until the next conversion completes. If no crossing arrives by count 1999, de-integration is cut short and an over-range flag is stored together with the value.

Top module: `dualslope_seq`

## Requirements
- R1: The phases always run autozero, then integrate, then de-integrate, then autozero again. At every cycle exactly one of azShort, intConnect and deintRef is high.
- R2: Autozero lasts AZ_CYCLES clocks (default 1000). azShort and azLoop are both high throughout it.
- R3: Integrate lasts exactly 1000 clocks, with intConnect high throughout.
- R4: In the last integrate cycle the synchronized comparator is stored as the input sign, where 1 means positive. refNeg carries the stored sign during the whole of de-integrate, so a positive input selects the negative reference.
- R5: The count is 0 in the first de-integrate cycle and rises by one each cycle. The comparator passes through a two-flop synchronizer. If the raw comparator differs from the stored sign from de-integrate cycle j onward, the crossing is seen in cycle j+2. That cycle is the last de-integrate cycle, and its count is the reading.
- R6: The reading is BCD. dispThou is a single bit holding 0 or 1. dispHund, dispTens and dispOnes are 4-bit digits from 0 to 9, and each decade carries into the next one when it passes 9.
- R7: If no crossing is seen in the cycle where the count is 1999, de-integrate ends after that cycle, the display shows 1999 and overRange is 1. A crossing seen in that same cycle takes priority: the display shows 1999 with overRange 0.
- R8: The display, dispNeg and overRange change only at the end of a conversion. convDone pulses high for one cycle, which is the first autozero cycle, and the new values are present in that cycle. dispNeg is 1 when the stored sign was 0.
- R9: A synchronous reset forces autozero, clears the count and clears the display, dispNeg, overRange and convDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cmpIn | input | 1 | Raw comparator output, 1 = integrator above zero |
| azShort | output | 1 | Short inputs to common (autozero phase) |
| azLoop | output | 1 | Close the autozero loop (autozero phase) |
| intConnect | output | 1 | Connect the signal input (integrate phase) |
| deintRef | output | 1 | Connect the reference (de-integrate phase) |
| refNeg | output | 1 | Reference polarity select, 1 = negative reference |
| dispThou | output | 1 | Latched thousands digit (0 or 1) |
| dispHund | output | 4 | Latched hundreds digit, BCD |
| dispTens | output | 4 | Latched tens digit, BCD |
| dispOnes | output | 4 | Latched ones digit, BCD |
| dispNeg | output | 1 | Latched sign, 1 = negative input |
| overRange | output | 1 | Latched over-range flag |
| convDone | output | 1 | One-cycle pulse when the display updates |

## Verification
Two events can fall in the same de-integrate cycle: the comparator crossing and the 1999 count limit. The bench forces this case by flipping the raw comparator so that, after the two synchronizer stages, the crossing arrives exactly when the count is 1999. It expects 1999 with overRange clear. A second run never flips the comparator, and there the expected result is 1999 with overRange set. Either mix-up in the priority shows up as a wrong flag. Readings are swept across every decade carry boundary with both input signs. Each expected digit is computed arithmetically from the cycle in which the bench flipped the comparator.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

  typedef enum logic [1:0] {
    PH_AZ    = 2'd0,
    PH_INT   = 2'd1,
    PH_DEINT = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic latch;
    logic overFlag;
  } dp_strobe_t;

endpackage

// File: rtl/dsl_bcd_decade.sv
module dsl_bcd_decade #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          carryIn,
  output logic [DW-1:0] digit,
  output logic          isNine,
  output logic          carryOut
);
  localparam logic [DW-1:0] NINE = DW'(9);

  assign isNine   = (digit == NINE);
  assign carryOut = carryIn && isNine;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      digit <= '0;
    end else if (carryIn) begin
      digit <= isNine ? '0 : digit + DW'(1);
    end
  end
endmodule

// File: rtl/dsl_ctrl.sv
module dsl_ctrl
  import dsl_pkg::*;
#(
  parameter int AZ_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmpIn,
  input  logic       cntIsIntEnd,
  input  logic       cntIsMax,
  output phase_t     phase,
  output dp_strobe_t strobe,
  output logic       signPos
);
  localparam int AZW = (AZ_CYCLES < 2) ? 1 : $clog2(AZ_CYCLES);
  localparam logic [AZW-1:0] AZ_LAST = AZW'(AZ_CYCLES - 1);

  logic [AZW-1:0] azCnt;
  logic           cmpMeta;
  logic           cmpSync;
  logic           crossing;

  // two-flop synchronizer for the asynchronous comparator
  always_ff @(posedge clk) begin
    if (rst) begin
      cmpMeta <= 1'b0;
      cmpSync <= 1'b0;
    end else begin
      cmpMeta <= cmpIn;
      cmpSync <= cmpMeta;
    end
  end

  assign crossing = (cmpSync != signPos);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_AZ;
      azCnt   <= '0;
      signPos <= 1'b0;
    end else begin
      unique case (phase)
        PH_AZ: begin
          if (azCnt == AZ_LAST) begin
            azCnt <= '0;
            phase <= PH_INT;
          end else begin
            azCnt <= azCnt + AZW'(1);
          end
        end
        PH_INT: begin
          if (cntIsIntEnd) begin
            signPos <= cmpSync;
            phase   <= PH_DEINT;
          end
        end
        PH_DEINT: begin
          if (crossing || cntIsMax) begin
            phase <= PH_AZ;
          end
        end
        default: phase <= PH_AZ;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    unique case (phase)
      PH_AZ: strobe.cntClear = 1'b1;
      PH_INT: begin
        strobe.cntClear = cntIsIntEnd;
        strobe.cntInc   = !cntIsIntEnd;
      end
      PH_DEINT: begin
        strobe.cntInc   = !crossing && !cntIsMax;
        strobe.latch    = crossing || cntIsMax;
        strobe.overFlag = !crossing;
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/dsl_datapath.sv
module dsl_datapath
  import dsl_pkg::*;
#(
  parameter int NDEC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_strobe_t        strobe,
  input  logic              signPos,
  output logic              cntIsIntEnd,
  output logic              cntIsMax,
  output logic              dispTop,
  output logic [4*NDEC-1:0] dispDec,
  output logic              dispNeg,
  output logic              overRange,
  output logic              convDone
);
  logic [NDEC:0]       carry;
  logic [NDEC-1:0]     nine;
  logic [4*NDEC-1:0]   cntDec;
  logic                cntTop;
  logic                allNines;

  assign carry[0] = strobe.cntInc;

  generate
    for (genvar g = 0; g < NDEC; g++) begin : g_dec
      dsl_bcd_decade #(.DW(4)) u_dec (
        .clk      (clk),
        .rst      (rst),
        .clear    (strobe.cntClear),
        .carryIn  (carry[g]),
        .digit    (cntDec[4*g +: 4]),
        .isNine   (nine[g]),
        .carryOut (carry[g+1])
      );
    end
  endgenerate

  // half digit: only ever 0 or 1
  always_ff @(posedge clk) begin
    if (rst || strobe.cntClear) begin
      cntTop <= 1'b0;
    end else if (carry[NDEC]) begin
      cntTop <= 1'b1;
    end
  end

  assign allNines    = &nine;
  assign cntIsIntEnd = allNines && !cntTop;
  assign cntIsMax    = allNines && cntTop;

  always_ff @(posedge clk) begin
    if (rst) begin
      dispTop   <= 1'b0;
      dispDec   <= '0;
      dispNeg   <= 1'b0;
      overRange <= 1'b0;
      convDone  <= 1'b0;
    end else begin
      convDone <= strobe.latch;
      if (strobe.latch) begin
        dispTop   <= cntTop;
        dispDec   <= cntDec;
        dispNeg   <= !signPos;
        overRange <= strobe.overFlag;
      end
    end
  end
endmodule

// File: rtl/dualslope_seq.sv
module dualslope_seq
  import dsl_pkg::*;
#(
  parameter int AZ_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmpIn,
  output logic       azShort,
  output logic       azLoop,
  output logic       intConnect,
  output logic       deintRef,
  output logic       refNeg,
  output logic       dispThou,
  output logic [3:0] dispHund,
  output logic [3:0] dispTens,
  output logic [3:0] dispOnes,
  output logic       dispNeg,
  output logic       overRange,
  output logic       convDone
);
  localparam int NDEC = 3;

  phase_t            phase;
  dp_strobe_t        strobe;
  logic              signPos;
  logic              cntIsIntEnd;
  logic              cntIsMax;
  logic [4*NDEC-1:0] dispDec;

  dsl_ctrl #(.AZ_CYCLES(AZ_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmpIn       (cmpIn),
    .cntIsIntEnd (cntIsIntEnd),
    .cntIsMax    (cntIsMax),
    .phase       (phase),
    .strobe      (strobe),
    .signPos     (signPos)
  );

  dsl_datapath #(.NDEC(NDEC)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .signPos     (signPos),
    .cntIsIntEnd (cntIsIntEnd),
    .cntIsMax    (cntIsMax),
    .dispTop     (dispThou),
    .dispDec     (dispDec),
    .dispNeg     (dispNeg),
    .overRange   (overRange),
    .convDone    (convDone)
  );

  assign azShort    = (phase == PH_AZ);
  assign azLoop     = (phase == PH_AZ);
  assign intConnect = (phase == PH_INT);
  assign deintRef   = (phase == PH_DEINT);
  assign refNeg     = signPos;
  assign dispHund   = dispDec[11:8];
  assign dispTens   = dispDec[7:4];
  assign dispOnes   = dispDec[3:0];
endmodule

// File: rtl/dsl_checker.sv
module dsl_checker (
  input logic       clk,
  input logic       rst,
  input logic       azShort,
  input logic       azLoop,
  input logic       intConnect,
  input logic       deintRef,
  input logic       refNeg,
  input logic       dispThou,
  input logic [3:0] dispHund,
  input logic [3:0] dispTens,
  input logic [3:0] dispOnes,
  input logic       dispNeg,
  input logic       overRange,
  input logic       convDone
);
  logic [10:0] intRun;

  always_ff @(posedge clk) begin
    if (rst || !intConnect) intRun <= '0;
    else                    intRun <= intRun + 11'd1;
  end

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $countones({azShort, intConnect, deintRef}) == 1);

  assert_az_to_int_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(azShort) && !$past(rst)) |-> intConnect);

  assert_int_to_deint_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(intConnect) && !$past(rst)) |-> deintRef);

  assert_deint_to_az_R1: assert property (@(posedge clk) disable iff (rst)
    ($fell(deintRef) && !$past(rst)) |-> azShort);

  assert_az_loop_R2: assert property (@(posedge clk) disable iff (rst)
    azLoop == azShort);

  assert_int_length_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(intConnect) && !$past(rst)) |-> (intRun == 11'd1000));

  assert_ref_held_R4: assert property (@(posedge clk) disable iff (rst)
    (deintRef && $past(deintRef) && !$past(rst)) |-> $stable(refNeg));

  assert_digits_bcd_R6: assert property (@(posedge clk) disable iff (rst)
    (dispHund <= 4'd9) && (dispTens <= 4'd9) && (dispOnes <= 4'd9));

  assert_over_is_max_R7: assert property (@(posedge clk) disable iff (rst)
    overRange |-> ({dispThou, dispHund, dispTens, dispOnes} == {1'b1, 4'd9, 4'd9, 4'd9}));

  assert_display_held_R8: assert property (@(posedge clk) disable iff (rst)
    (!convDone && !$past(rst)) |->
      $stable({dispThou, dispHund, dispTens, dispOnes, dispNeg, overRange}));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    convDone |-> azShort);
endmodule

bind dualslope_seq dsl_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .azShort    (azShort),
  .azLoop     (azLoop),
  .intConnect (intConnect),
  .deintRef   (deintRef),
  .refNeg     (refNeg),
  .dispThou   (dispThou),
  .dispHund   (dispHund),
  .dispTens   (dispTens),
  .dispOnes   (dispOnes),
  .dispNeg    (dispNeg),
  .overRange  (overRange),
  .convDone   (convDone)
);

// File: tb/sim_dualslope_seq.sv
`timescale 1ns/1ps
module sim_dualslope_seq;
  localparam int AZ = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmpIn = 1'b1;
  logic       azShort, azLoop, intConnect, deintRef, refNeg;
  logic       dispThou, dispNeg, overRange, convDone;
  logic [3:0] dispHund, dispTens, dispOnes;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int prevVal = -1;

  always #5 clk = ~clk;

  dualslope_seq #(.AZ_CYCLES(AZ)) u0 (
    .clk(clk), .rst(rst), .cmpIn(cmpIn),
    .azShort(azShort), .azLoop(azLoop), .intConnect(intConnect),
    .deintRef(deintRef), .refNeg(refNeg),
    .dispThou(dispThou), .dispHund(dispHund), .dispTens(dispTens),
    .dispOnes(dispOnes), .dispNeg(dispNeg), .overRange(overRange),
    .convDone(convDone)
  );

  function automatic int shown();
    return int'(dispThou) * 1000 + int'(dispHund) * 100 + int'(dispTens) * 10 + int'(dispOnes);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // one conversion; entered at a negedge during autozero
  // n: target reading (>=2), pos: input sign, noCross: never flip comparator
  task automatic runConv(input int n, input bit pos, input bit noCross, input bit measAz);
    int azCount = 0;
    int intCount = 0;
    int deCount = 0;
    int expVal;
    int j = 0;
    cmpIn = pos;
    while (!intConnect) begin
      if (azShort) azCount++;
      check(azLoop == azShort, "R2 loop", azLoop, azShort);
      @(negedge clk);
    end
    if (measAz) check(azCount == AZ, "R2 length", azCount, AZ);
    if (prevVal >= 0) check(shown() == prevVal, "R8 held", shown(), prevVal);
    while (intConnect) begin
      intCount++;
      @(negedge clk);
    end
    check(intCount == 1000, "R3 length", intCount, 1000);
    check(deintRef == 1'b1, "R1 order", deintRef, 1);
    check(refNeg == pos, "R4 polarity", refNeg, pos);
    while (!convDone && j < 2100) begin
      if (deintRef) deCount++;
      if (!noCross && j == n - 2) cmpIn = !pos;
      j++;
      @(negedge clk);
    end
    expVal = noCross ? 1999 : n;
    check(azShort == 1'b1, "R8 done in autozero", azShort, 1);
    check(shown() == expVal, "R5 R6 reading", shown(), expVal);
    check(dispThou == (expVal / 1000), "R6 thousands", dispThou, expVal / 1000);
    check(dispHund == (expVal / 100) % 10, "R6 hundreds", dispHund, (expVal / 100) % 10);
    check(dispOnes == expVal % 10, "R6 ones", dispOnes, expVal % 10);
    check(deCount == expVal + 1, "R5 deint cycles", deCount, expVal + 1);
    check(overRange == noCross, "R7 over flag", overRange, noCross);
    check(dispNeg == !pos, "R8 sign", dispNeg, !pos);
    prevVal = expVal;
  endtask

  initial begin
    int vals[12] = '{2, 9, 10, 11, 99, 100, 101, 999, 1000, 1001, 1234, 1999};
    repeat (3) @(negedge clk);
    check(azShort && !intConnect && !deintRef, "R9 phase", {azShort, intConnect, deintRef}, 3'b100);
    check(shown() == 0, "R9 display", shown(), 0);
    check(!dispNeg && !overRange && !convDone, "R9 flags", {dispNeg, overRange, convDone}, 0);
    rst = 1'b0;
    for (int k = 0; k < 12; k++) begin
      runConv(vals[k], (k % 2) == 0, 1'b0, k != 0);
    end
    // crossing and limit collide at 1999 (last entry above); now no crossing at all
    runConv(0, 1'b1, 1'b1, 1'b1);
    runConv(0, 1'b0, 1'b1, 1'b1);
    // R9: reset in the middle of de-integrate
    cmpIn = 1'b1;
    while (!deintRef) @(negedge clk);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(azShort && !deintRef, "R9 mid reset phase", azShort, 1);
    check(shown() == 0 && !overRange && !dispNeg, "R9 mid reset display", shown(), 0);
    rst = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule